// File: doc/BRIEF.md
# Interrupt Combiner with Event and Level Sources

This block gathers the interrupt sources of one peripheral into a single interrupt line. Each source position is classed by a parameter mask as either an event source or a level source. An event source is captured in a sticky flag as soon as its input goes high, and the flag stays set until software clears it. A level source is never stored; its position always reflects the live input, so the only way to remove it is to remove the condition that drives it.

Software reaches the block through a write strobe and a read strobe, each with a two-bit view selector and a data word. There are four views: the raw flags, the enabled flags, an enable-set view and an enable-clear view. Writing ones to the raw view forces event flags, which is useful for testing the interrupt path. Writing ones to the enabled-flags view clears event flags. The two enable views give atomic set and clear of individual enable bits, so no read-modify-write is needed. The interrupt output is high whenever any enabled position of the raw flags is high.

Top module: `intc_combiner`

## Requirements
- R1: An event position latches to 1 in the clock edge at which its input is high and stays 1 until software clears it.
- R2: A level position in the raw view equals its live input and holds no memory once the input falls.
- R3: Reading view 0 (raw) returns the latched event flags ORed with the live inputs in bits N_SRC-1:0.
- R4: Reading view 1 (flags) returns the raw value ANDed with the enable mask.
- R5: `irq_o` is high exactly when some position of raw AND enable is 1, in the same cycle as the input change, with no register in the path.
- R6: Writing ones to view 0 sets the matching event flags; ones at level positions have no effect.
- R7: Writing ones to view 1 clears the matching event flags; a level position stays high while its input is high.
- R8: Writing ones to view 2 sets enable bits and writing ones to view 3 clears them; zero bits in either write leave the mask unchanged.
- R9: Reading view 2 or view 3 returns the enable mask; bits at positions N_SRC and above read 0 and cannot be set.
- R10: When an event input is high in the same cycle as a software clear of that flag, the flag ends set.
- R11: While `rst_n` is low at a clock edge, all event flags, all enables and `rd_data_o` are cleared, so `irq_o` is low after reset.
- R12: `rd_data_o` is registered: it takes the selected view at the edge where `rd_en_i` is high and holds its value in all other cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| src_i | input | N_SRC | Interrupt source inputs |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | 2 | Write view: 0 raw, 1 flags, 2 enable-set, 3 enable-clear |
| wr_data_i | input | DATA_W | Write data |
| rd_en_i | input | 1 | Read strobe |
| rd_addr_i | input | 2 | Read view, same encoding as writes |
| rd_data_o | output | DATA_W | Read data, valid the cycle after the strobe |
| irq_o | output | 1 | Combined interrupt |

## Verification
The bench builds the block with six sources, an eight-bit data word and an event mask of 6'b001111, so positions 0 to 3 are event sources and 4 to 5 are level sources. Having both classes in one instance lets every software write be aimed at a mix of event and level positions and shows the level positions refusing to be set or cleared. The two spare data bits above the source count make the unused enable positions observable, so an attempt to set them can be seen reading back as zero.

// File: rtl/intc_pkg.sv
// Shared definitions for the interrupt combiner.
// Assumes a fixed set of four software views selected by a two-bit code.
package intc_pkg;

    localparam int VIEW_W = 2;

    typedef enum logic [VIEW_W-1:0] {
        VIEW_RAW   = 2'd0,
        VIEW_FLAGS = 2'd1,
        VIEW_ENSET = 2'd2,
        VIEW_ENCLR = 2'd3
    } view_e;

endpackage

// File: rtl/intc_src_bank.sv
// Source bank: one sticky flag per event position, nothing stored for
// level positions. Produces the raw view (flags ORed with live inputs).
// Assumes set/clear masks arrive already decoded for this cycle.
module intc_src_bank #(
    parameter int                N_SRC      = 12,
    parameter logic [N_SRC-1:0]  EVENT_MASK = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src_i,
    input  logic [N_SRC-1:0] set_i,
    input  logic [N_SRC-1:0] clr_i,
    output logic [N_SRC-1:0] lat_o,
    output logic [N_SRC-1:0] raw_o
);

    // Level positions never look at the software masks.
    logic unused_lvl;
    assign unused_lvl = ^((set_i | clr_i) & ~EVENT_MASK);

    for (genvar g = 0; g < N_SRC; g++) begin : g_pos
        if (EVENT_MASK[g]) begin : g_evt
            logic flag_q;
            // Sticky flag: hardware or software set beats software clear.
            always_ff @(posedge clk) begin
                if (!rst_n) flag_q <= 1'b0;
                else        flag_q <= src_i[g] | set_i[g] | (flag_q & ~clr_i[g]);
            end
            assign lat_o[g] = flag_q;
        end else begin : g_lvl
            assign lat_o[g] = 1'b0;
        end
    end

    // Raw view merges stored flags and live inputs.
    assign raw_o = lat_o | src_i;

endmodule

// File: rtl/intc_en_reg.sv
// Enable mask with separate set and clear strobes.
// Assumes set and clear never address the same cycle (distinct views).
module intc_en_reg #(
    parameter int N_SRC = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] set_i,
    input  logic [N_SRC-1:0] clr_i,
    output logic [N_SRC-1:0] en_o
);

    logic [N_SRC-1:0] en_q;

    // Apply set then clear masks; zero bits keep the stored value.
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= '0;
        else        en_q <= (en_q | set_i) & ~clr_i;
    end

    assign en_o = en_q;

endmodule

// File: rtl/intc_read_port.sv
// Registered read mux over the four views, zero-extended to DATA_W.
// Assumes DATA_W >= N_SRC.
module intc_read_port #(
    parameter int N_SRC  = 12,
    parameter int DATA_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rd_en_i,
    input  intc_pkg::view_e      sel_i,
    input  logic [N_SRC-1:0]     raw_i,
    input  logic [N_SRC-1:0]     en_i,
    output logic [DATA_W-1:0]    rd_data_o
);

    import intc_pkg::*;

    logic [DATA_W-1:0] rd_q;
    logic [DATA_W-1:0] word_d;

    // Select the view and widen it.
    always_comb begin
        unique case (sel_i)
            VIEW_RAW:   word_d = DATA_W'(raw_i);
            VIEW_FLAGS: word_d = DATA_W'(raw_i & en_i);
            VIEW_ENSET: word_d = DATA_W'(en_i);
            VIEW_ENCLR: word_d = DATA_W'(en_i);
            default:    word_d = '0;
        endcase
    end

    // Capture on a read strobe, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)       rd_q <= '0;
        else if (rd_en_i) rd_q <= word_d;
    end

    assign rd_data_o = rd_q;

endmodule

// File: rtl/intc_combiner.sv
// Interrupt combiner top: decodes software writes into per-view masks,
// holds the source bank and enable mask, drives the combined interrupt.
// Assumes DATA_W >= N_SRC and a synchronous, single-clock register port.
module intc_combiner #(
    parameter int                N_SRC      = 12,
    parameter int                DATA_W     = 16,
    parameter logic [N_SRC-1:0]  EVENT_MASK = 12'h0FF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  src_i,
    input  logic              wr_en_i,
    input  logic [1:0]        wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              rd_en_i,
    input  logic [1:0]        rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              irq_o
);

    import intc_pkg::*;

    view_e            wsel;
    view_e            rsel;
    logic [N_SRC-1:0] wbits;
    logic [N_SRC-1:0] flag_set, flag_clr, en_set, en_clr;
    logic [N_SRC-1:0] lat, raw, en_q;
    logic             unused_hi;

    assign wsel  = view_e'(wr_addr_i);
    assign rsel  = view_e'(rd_addr_i);
    assign wbits = wr_data_i[N_SRC-1:0];
    // Data bits above the source count are dropped on purpose.
    assign unused_hi = ^(wr_data_i >> N_SRC);

    // Decode one write into the four per-view masks.
    always_comb begin
        flag_set = '0;
        flag_clr = '0;
        en_set   = '0;
        en_clr   = '0;
        if (wr_en_i) begin
            unique case (wsel)
                VIEW_RAW:   flag_set = wbits & EVENT_MASK;
                VIEW_FLAGS: flag_clr = wbits & EVENT_MASK;
                VIEW_ENSET: en_set   = wbits;
                VIEW_ENCLR: en_clr   = wbits;
                default:    ;
            endcase
        end
    end

    intc_src_bank #(.N_SRC(N_SRC), .EVENT_MASK(EVENT_MASK)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .src_i (src_i),
        .set_i (flag_set),
        .clr_i (flag_clr),
        .lat_o (lat),
        .raw_o (raw)
    );

    intc_en_reg #(.N_SRC(N_SRC)) u_en (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (en_set),
        .clr_i (en_clr),
        .en_o  (en_q)
    );

    intc_read_port #(.N_SRC(N_SRC), .DATA_W(DATA_W)) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en_i   (rd_en_i),
        .sel_i     (rsel),
        .raw_i     (raw),
        .en_i      (en_q),
        .rd_data_o (rd_data_o)
    );

    // Combined interrupt, unregistered so live inputs show at once.
    assign irq_o = |(raw & en_q);

endmodule

// File: rtl/intc_chk.sv
// Property checker for the interrupt combiner, bound into every instance.
// Assumes the view encoding of intc_pkg.
module intc_chk #(
    parameter int                N_SRC      = 12,
    parameter int                DATA_W     = 16,
    parameter logic [N_SRC-1:0]  EVENT_MASK = 12'h0FF
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N_SRC-1:0]  src_i,
    input logic              wr_en_i,
    input logic [1:0]        wr_addr_i,
    input logic [DATA_W-1:0] wr_data_i,
    input logic              rd_en_i,
    input logic [1:0]        rd_addr_i,
    input logic [DATA_W-1:0] rd_data_o,
    input logic              irq_o,
    input logic [N_SRC-1:0]  lat,
    input logic [N_SRC-1:0]  en_q
);

    logic [N_SRC-1:0] clr_now, enset_now;
    logic             rd_raw, rd_en_view;
    logic             unused_chk;

    assign clr_now    = (wr_en_i && wr_addr_i == 2'd1) ? wr_data_i[N_SRC-1:0] : '0;
    assign enset_now  = (wr_en_i && wr_addr_i == 2'd2) ? wr_data_i[N_SRC-1:0] : '0;
    assign rd_raw     = rd_en_i && rd_addr_i == 2'd0;
    assign rd_en_view = rd_en_i && rd_addr_i[1];
    assign unused_chk = ^(wr_data_i >> N_SRC);

    // R1
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((($past(lat) & ~$past(clr_now)) & ~lat) == '0));

    // R10
    latch_catch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((($past(src_i) & EVENT_MASK) & ~lat) == '0));

    // R2
    level_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rd_raw)) |->
            ((rd_data_o[N_SRC-1:0] & ~EVENT_MASK) == ($past(src_i) & ~EVENT_MASK)));

    // R9
    en_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rd_en_view)) |-> ((rd_data_o >> N_SRC) == '0));

    // R8
    en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (($past(enset_now) & ~en_q) == '0));

    // R5
    irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((src_i & en_q & ~EVENT_MASK) != '0) |-> irq_o);

    // R11
    rst_quiet_chk: assert property (@(posedge clk)
        $past(!rst_n) |-> (!irq_o && en_q == '0 && lat == '0 && rd_data_o == '0));

endmodule

bind intc_combiner intc_chk #(
    .N_SRC(N_SRC), .DATA_W(DATA_W), .EVENT_MASK(EVENT_MASK)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_i     (src_i),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .rd_en_i   (rd_en_i),
    .rd_addr_i (rd_addr_i),
    .rd_data_o (rd_data_o),
    .irq_o     (irq_o),
    .lat       (lat),
    .en_q      (en_q)
);

// File: tb/sim_intc_combiner.sv
module sim_intc_combiner;

    localparam int N_SRC  = 6;
    localparam int DATA_W = 8;
    localparam logic [N_SRC-1:0] EV = 6'b001111;
    localparam int NV = 12;

    // {src[5:0], wr, waddr[1:0], wdata[7:0], raddr[1:0], exp_rd[7:0], exp_irq}
    localparam logic [27:0] VEC [NV] = '{
        {6'h00, 1'b0, 2'd0, 8'h00, 2'd0, 8'h00, 1'b0}, // R3 idle raw
        {6'h01, 1'b0, 2'd0, 8'h00, 2'd0, 8'h01, 1'b0}, // R1 event seen
        {6'h00, 1'b0, 2'd0, 8'h00, 2'd0, 8'h01, 1'b0}, // R1 flag sticks
        {6'h00, 1'b1, 2'd2, 8'hFF, 2'd2, 8'h3F, 1'b1}, // R8 R9 R5 enable all
        {6'h00, 1'b1, 2'd1, 8'h01, 2'd0, 8'h00, 1'b0}, // R7 clear flag
        {6'h10, 1'b0, 2'd0, 8'h00, 2'd0, 8'h10, 1'b1}, // R2 level live
        {6'h00, 1'b0, 2'd0, 8'h00, 2'd0, 8'h00, 1'b0}, // R2 level gone
        {6'h00, 1'b1, 2'd0, 8'h32, 2'd0, 8'h02, 1'b1}, // R6 force, level ignored
        {6'h00, 1'b1, 2'd3, 8'h02, 2'd1, 8'h00, 1'b0}, // R8 R4 disable bit1
        {6'h20, 1'b1, 2'd1, 8'h20, 2'd1, 8'h20, 1'b1}, // R7 R4 level not cleared
        {6'h00, 1'b1, 2'd3, 8'h00, 2'd3, 8'h3D, 1'b0}, // R8 zero write no effect
        {6'h00, 1'b1, 2'd1, 8'h02, 2'd0, 8'h00, 1'b0}  // R7 clear forced flag
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [N_SRC-1:0]  src = '0;
    logic              wr_en = 1'b0;
    logic [1:0]        wr_addr = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic              rd_en = 1'b0;
    logic [1:0]        rd_addr = '0;
    logic [DATA_W-1:0] rd_data;
    logic              irq;

    int n_chk = 0;
    int n_err = 0;

    always #10 clk = ~clk;

    intc_combiner #(.N_SRC(N_SRC), .DATA_W(DATA_W), .EVENT_MASK(EV)) u0 (
        .clk(clk), .rst_n(rst_n), .src_i(src),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .rd_en_i(rd_en), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
        .irq_o(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [DATA_W-1:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [DATA_W-1:0] d);
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [DATA_W-1:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R11 reset state
        chk("R11 irq after reset", irq, 0);
        chk("R11 rd_data after reset", rd_data, 0);
        for (int a = 0; a < 4; a++) begin
            rd(a[1:0], d);
            chk("R11 view after reset", d, 0);
        end

        // table walk
        for (int i = 0; i < NV; i++) begin
            logic [27:0] v;
            v = VEC[i];
            src = v[27:22];
            if (v[21]) wr(v[20:19], v[18:11]);
            else @(negedge clk);
            rd(v[10:9], d);
            chk($sformatf("R3 table[%0d] read", i), d, v[8:1]);
            chk($sformatf("R5 table[%0d] irq", i), irq, v[0]);
        end
        // state now: flags 0, enable 3D

        // R10 set beats clear in the same cycle
        src = 6'h04;
        wr(2'd1, 8'h04);
        src = '0;
        rd(2'd0, d);
        chk("R10 set wins over clear", d, 8'h04);
        wr(2'd1, 8'h04);
        rd(2'd0, d);
        chk("R7 clear after race", d, 8'h00);

        // R5 unregistered path: irq follows input before any edge
        chk("R5 irq low before input", irq, 0);
        src = 6'h08;
        #1;
        chk("R5 irq same cycle", irq, 1);
        @(negedge clk);
        src = '0;
        wr(2'd1, 8'h08);
        chk("R5 irq after clear", irq, 0);

        // R12 read data holds without a strobe
        rd(2'd0, d);
        src = 6'h10;
        repeat (2) @(negedge clk);
        chk("R12 rd_data holds", rd_data, 8'h00);
        src = '0;

        // R9 padding enables cannot be set
        wr(2'd2, 8'hC0);
        rd(2'd2, d);
        chk("R9 enable-set view", d, 8'h3D);
        rd(2'd3, d);
        chk("R9 enable-clear view", d, 8'h3D);

        // R11 reset mid-run
        wr(2'd0, 8'h0F);
        chk("R6 forced flags raise irq", irq, 1);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R11 irq after mid reset", irq, 0);
        rd(2'd0, d);
        chk("R11 flags cleared", d, 8'h00);
        rd(2'd2, d);
        chk("R11 enables cleared", d, 8'h00);
        src = 6'h01;
        @(negedge clk);
        src = '0;
        chk("R11 no irq with enables cleared", irq, 0);
        rd(2'd1, d);
        chk("R4 flags view masked", d, 8'h00);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule